// File: doc/BRIEF.md
# Bus-Matching Port FIFO

This block is a 512-bit first-in first-out buffer placed between a narrow external pin port and a wide on-chip memory bus. A control word chooses the direction at run time. In input mode, chunks sampled from the pins are packed into words, and the memory side reads them. In output mode, the memory side writes words, and the block unpacks them into chunks that it drives onto the pins. Narrow chunks (8 or 16 bits) build 32-bit units. Wider chunks (12 or 24 bits) build 96-bit units. The memory side moves one 32-bit word or four words (128 bits) per request.

The external port clock is represented by a fast clock `clk`, a phase index `port_phase` that counts through the phases of one port-clock period, and a request line `port_en`. A pin event takes place only in the phase that the control word selects. Storage is sixteen 32-bit words. A 96-bit unit takes three words, so the 96-bit modes use fifteen words.

The pin side is managed by a three-state machine. `ST_PACK` collects input chunks. `ST_LOAD` waits for an output event and fetches a whole unit. `ST_SHIFT` drives the remaining chunks of that unit. The transitions are:
- A control write enters `ST_PACK` (input) or `ST_LOAD` (output).
- `ST_LOAD` goes to `ST_SHIFT` when an event finds a full unit stored.
- `ST_SHIFT` returns to `ST_LOAD` after the event that drives the unit's last chunk.

Top module: `port_fifo`

## Requirements
- R1: After reset the block is empty. `full`, `overflow`, `underflow` and `mem_ack` are 0. `port_dout` is 0. The mode is input, with 8-bit chunks and phase 0.
- R2: The control word has three fields. Bit 0 is the direction (0 = pins to memory, 1 = memory to pins). Bits 2:1 are the chunk mode (0 = 8-bit into 32, 1 = 16-bit into 32, 2 = 12-bit into 96, 3 = 24-bit into 96). Bits 5:3 are the sampling phase. All other bits are ignored.
- R3: A pin event happens on a rising edge of `clk` only when `port_en` is 1 and `port_phase` equals the programmed phase. At any other time the pin inputs have no effect.
- R4: In input mode the first chunk of a unit lands in the lowest bits. `port_din` bits above the chunk width are ignored. A finished unit is stored as one word, or as three words with bits 31:0 first.
- R5: A memory read in input mode returns data and `mem_ack` one cycle after the request. A narrow read returns the oldest word in bits 31:0 with the upper bits zero. A wide read returns the four oldest words, with the oldest in bits 31:0.
- R6: Capacity is 16 words in the 32-bit modes and 15 words in the 96-bit modes. `empty` is 1 when no word is stored. `full` is 1 when the free space is smaller than one unit.
- R7: If a unit completes in input mode while there is no room for it, the unit is dropped and `overflow` is set. `overflow` stays set until the next control write.
- R8: If an output event needs a new unit while less than one unit is stored, `underflow` is set and stays set, and `port_dout` holds its value. The next event tries the unit's first chunk again.
- R9: A narrow read needs at least 1 stored word. A wide read needs at least 4 stored words. A narrow write needs 1 free word. A wide write needs 4 free words. A refused request gets no `mem_ack` and changes nothing.
- R10: In output mode a narrow write stores `mem_wdata[31:0]`. A wide write stores four words, with bits 31:0 first. Each event puts the next chunk of the oldest unit on `port_dout`, lowest chunk first and zero-extended. The value appears after that edge.
- R11: A control write clears storage, packing state, both sticky flags, `mem_ack` and `port_dout`. It overrides every other input in the same cycle.
- R12: A memory request that does not match the direction is ignored, with no `mem_ack`. This covers a write in input mode and a read in output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, several phases per port-clock period |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 32 | Control word |
| port_en | input | 1 | Pin event request |
| port_phase | input | 3 | Current phase of the port clock |
| port_din | input | PIN_W | Chunk from the pins (input mode) |
| port_dout | output | PIN_W | Chunk to the pins (output mode) |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| mem_wide | input | 1 | 1 = four words, 0 = one word |
| mem_wdata | input | 4*WORD_W | Memory write data |
| mem_ack | output | 1 | Request accepted, one cycle later |
| mem_rdata | output | 4*WORD_W | Memory read data, valid with `mem_ack` |
| full | output | 1 | Less than one unit free |
| empty | output | 1 | No word stored |
| overflow | output | 1 | Sticky: an input unit was dropped |
| underflow | output | 1 | Sticky: an output event found too little data |

## Verification
`port_dout`, the sticky flags, `full` and `empty` all change on the same rising edge that samples the event, request or control write that affects them. `mem_ack` and `mem_rdata` follow their request by exactly one cycle. The bench runs a queue-based model on each rising edge and compares every output against it at the next falling edge. Each result is therefore checked in the cycle it is due, neither early nor late.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    typedef enum logic [1:0] {
        CH_8  = 2'd0,
        CH_16 = 2'd1,
        CH_12 = 2'd2,
        CH_24 = 2'd3
    } chunk_mode_e;

    typedef enum logic [1:0] {
        ST_PACK  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } port_state_e;

    typedef struct packed {
        logic [2:0]  phase;
        chunk_mode_e mode;
        logic        dir;
    } ctrl_t;

    function automatic logic [4:0] chunk_width(chunk_mode_e m);
        case (m)
            CH_8:    return 5'd8;
            CH_16:   return 5'd16;
            CH_12:   return 5'd12;
            default: return 5'd24;
        endcase
    endfunction

    function automatic logic [3:0] chunk_count(chunk_mode_e m);
        case (m)
            CH_8:    return 4'd4;
            CH_16:   return 4'd2;
            CH_12:   return 4'd8;
            default: return 4'd4;
        endcase
    endfunction

    function automatic logic [1:0] unit_words(chunk_mode_e m);
        return m[1] ? 2'd3 : 2'd1;
    endfunction

endpackage

// File: rtl/pfifo_ram.sv
module pfifo_ram #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    parameter int AW     = $clog2(DEPTH),
    parameter int NW     = $clog2(LANES + 1)
) (
    input  logic                      clk,
    input  logic [NW-1:0]             wr_cnt,
    input  logic [AW-1:0]             wr_ptr,
    input  logic [LANES*WORD_W-1:0]   wr_data,
    input  logic [AW-1:0]             rd_ptr,
    output logic [LANES*WORD_W-1:0]   rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Up to LANES consecutive words written from wr_ptr, wrapping.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(wr_cnt)) begin
                mem[wr_ptr + AW'(i)] <= wr_data[i*WORD_W +: WORD_W];
            end
        end
    end

    // LANES consecutive words visible from rd_ptr, oldest in lane 0.
    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign rd_data[g*WORD_W +: WORD_W] = mem[rd_ptr + AW'(g)];
    end

endmodule

// File: rtl/pfifo_lane_sel.sv
module pfifo_lane_sel
    import pfifo_pkg::*;
#(
    parameter int UNIT_W = 96,
    parameter int PIN_W  = 24
) (
    input  logic [UNIT_W-1:0] unit,
    input  chunk_mode_e       mode,
    input  logic [2:0]        idx,
    output logic [PIN_W-1:0]  chunk
);

    logic [4:0]       w;
    logic [6:0]       shamt;
    logic [PIN_W-1:0] mask;

    always_comb begin
        w     = chunk_width(mode);
        shamt = 7'(idx) * 7'(w);
        mask  = PIN_W'((32'd1 << w) - 32'd1);
        chunk = PIN_W'(unit >> shamt) & mask;
    end

endmodule

// File: rtl/port_fifo.sv
module port_fifo
    import pfifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int PIN_W  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [31:0]           cfg_wdata,
    input  logic                  port_en,
    input  logic [2:0]            port_phase,
    input  logic [PIN_W-1:0]      port_din,
    output logic [PIN_W-1:0]      port_dout,
    input  logic                  mem_rd,
    input  logic                  mem_wr,
    input  logic                  mem_wide,
    input  logic [4*WORD_W-1:0]   mem_wdata,
    output logic                  mem_ack,
    output logic [4*WORD_W-1:0]   mem_rdata,
    output logic                  full,
    output logic                  empty,
    output logic                  overflow,
    output logic                  underflow
);

    localparam int LANES  = 4;
    localparam int BUS_W  = LANES * WORD_W;
    localparam int UNIT_W = 3 * WORD_W;
    localparam int AW     = $clog2(DEPTH);
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int NW     = $clog2(LANES + 1);
    localparam int CAP96  = (DEPTH / 3) * 3;

    ctrl_t             cfg_q;
    port_state_e       st, st_nx;
    logic [AW-1:0]     wp, rp;
    logic [CW-1:0]     cnt;
    logic [UNIT_W-1:0] unit_q;
    logic [2:0]        idx_q;
    logic              dir_out;
    logic              unused_cfg_bits;

    logic [CW-1:0]     capn, room, uw, mem_n, push_n, pop_n;
    logic [4:0]        w;
    logic [3:0]        n;
    logic [6:0]        shamt;
    logic [PIN_W-1:0]  cmask;
    logic [UNIT_W-1:0] pack_nx;
    logic              tick, last;
    logic              mem_rd_ok, mem_wr_ok, push_unit, ovf_set, load_ok, unf_set;
    logic [BUS_W-1:0]  ram_wdata, rd_data;
    logic [UNIT_W-1:0] sel_unit;
    logic [2:0]        sel_idx;
    logic [PIN_W-1:0]  chunk;

    assign dir_out         = cfg_q.dir;
    assign unused_cfg_bits = ^cfg_wdata[31:6];

    // Datapath decode
    always_comb begin
        w         = chunk_width(cfg_q.mode);
        n         = chunk_count(cfg_q.mode);
        uw        = CW'(unit_words(cfg_q.mode));
        capn      = cfg_q.mode[1] ? CW'(CAP96) : CW'(DEPTH);
        room      = capn - cnt;
        full      = room < uw;
        empty     = (cnt == '0);
        mem_n     = mem_wide ? CW'(4) : CW'(1);
        tick      = port_en && (port_phase == cfg_q.phase);
        last      = (4'(idx_q) == n - 4'd1);
        shamt     = 7'(idx_q) * 7'(w);
        cmask     = PIN_W'((32'd1 << w) - 32'd1);
        pack_nx   = unit_q | (UNIT_W'(port_din & cmask) << shamt);
        mem_rd_ok = !cfg_q.dir && mem_rd && (cnt >= mem_n);
        mem_wr_ok = cfg_q.dir && mem_wr && (room >= mem_n);
        push_unit = (st == ST_PACK) && tick && last && (room >= uw);
        ovf_set   = (st == ST_PACK) && tick && last && (room < uw);
        load_ok   = (st == ST_LOAD) && tick && (cnt >= uw);
        unf_set   = (st == ST_LOAD) && tick && (cnt < uw);
        pop_n     = mem_rd_ok ? mem_n : (load_ok ? uw : '0);
        push_n    = mem_wr_ok ? mem_n : (push_unit ? uw : '0);
        ram_wdata = mem_wr_ok ? mem_wdata : {{WORD_W{1'b0}}, pack_nx};
        sel_unit  = (st == ST_LOAD) ? rd_data[UNIT_W-1:0] : unit_q;
        sel_idx   = (st == ST_LOAD) ? 3'd0 : idx_q;
    end

    pfifo_ram #(
        .DEPTH (DEPTH),
        .WORD_W(WORD_W),
        .LANES (LANES)
    ) u_ram (
        .clk    (clk),
        .wr_cnt (NW'(push_n)),
        .wr_ptr (wp),
        .wr_data(ram_wdata),
        .rd_ptr (rp),
        .rd_data(rd_data)
    );

    pfifo_lane_sel #(
        .UNIT_W(UNIT_W),
        .PIN_W (PIN_W)
    ) u_sel (
        .unit (sel_unit),
        .mode (cfg_q.mode),
        .idx  (sel_idx),
        .chunk(chunk)
    );

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_PACK:  st_nx = ST_PACK;
            ST_LOAD:  if (load_ok) st_nx = ST_SHIFT;
            ST_SHIFT: if (tick && last) st_nx = ST_LOAD;
            default:  st_nx = ST_PACK;
        endcase
        if (cfg_we) begin
            st_nx = cfg_wdata[0] ? ST_LOAD : ST_PACK;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_PACK;
        else        st <= st_nx;
    end

    // Registered outputs and datapath state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            wp        <= '0;
            rp        <= '0;
            cnt       <= '0;
            unit_q    <= '0;
            idx_q     <= '0;
            port_dout <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (cfg_we) begin
            cfg_q     <= ctrl_t'(cfg_wdata[5:0]);
            wp        <= '0;
            rp        <= '0;
            cnt       <= '0;
            unit_q    <= '0;
            idx_q     <= '0;
            port_dout <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            wp        <= wp + AW'(push_n);
            rp        <= rp + AW'(pop_n);
            cnt       <= cnt + push_n - pop_n;
            mem_ack   <= mem_rd_ok || mem_wr_ok;
            overflow  <= overflow || ovf_set;
            underflow <= underflow || unf_set;
            if (mem_rd_ok) begin
                mem_rdata <= mem_wide ? rd_data
                                      : {{(BUS_W-WORD_W){1'b0}}, rd_data[WORD_W-1:0]};
            end
            unique case (st)
                ST_PACK: begin
                    if (tick) begin
                        unit_q <= last ? '0 : pack_nx;
                        idx_q  <= last ? 3'd0 : idx_q + 3'd1;
                    end
                end
                ST_LOAD: begin
                    if (load_ok) begin
                        unit_q    <= rd_data[UNIT_W-1:0];
                        port_dout <= chunk;
                        idx_q     <= 3'd1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        port_dout <= chunk;
                        idx_q     <= last ? 3'd0 : idx_q + 3'd1;
                    end
                end
                default: idx_q <= 3'd0;
            endcase
        end
    end

endmodule

// File: rtl/pfifo_checker.sv
module pfifo_checker #(
    parameter int PIN_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             dir_out,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             mem_wide,
    input logic             mem_ack,
    input logic             full,
    input logic             empty,
    input logic             overflow,
    input logic             underflow,
    input logic [PIN_W-1:0] port_dout
);

    // R6: a unit always fits in an empty store
    a_r6_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R7: overflow is sticky
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !cfg_we) |=> overflow);

    // R8: underflow is sticky
    a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !cfg_we) |=> underflow);

    // R8: output held when underflow first appears
    a_r8_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $stable(port_dout));

    // R11: control write clears flags, store and ack
    a_r11_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!overflow && !underflow && empty && !mem_ack));

    // R9: narrow read from empty store refused
    a_r9_empty_read_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !dir_out && mem_rd && !mem_wide && empty) |=> !mem_ack);

    // R12: input mode acks only reads
    a_r12_input_no_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !dir_out && !mem_rd) |=> !mem_ack);

    // R12: output mode acks only writes
    a_r12_output_no_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && dir_out && !mem_wr) |=> !mem_ack);

endmodule

bind port_fifo pfifo_checker #(.PIN_W(PIN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .dir_out  (dir_out),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_wide (mem_wide),
    .mem_ack  (mem_ack),
    .full     (full),
    .empty    (empty),
    .overflow (overflow),
    .underflow(underflow),
    .port_dout(port_dout)
);

// File: tb/tb_port_fifo.sv
module tb_port_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int PIN_W      = 24;
    localparam int MAX_CYC    = 200000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [31:0]  cfg_wdata = '0;
    logic         port_en = 1'b0;
    logic [2:0]   port_phase = '0;
    logic [PIN_W-1:0] port_din = '0;
    logic [PIN_W-1:0] port_dout;
    logic         mem_rd = 1'b0, mem_wr = 1'b0, mem_wide = 1'b0;
    logic [127:0] mem_wdata = '0;
    logic         mem_ack;
    logic [127:0] mem_rdata;
    logic         full, empty, overflow, underflow;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    running  = 1'b0;
    string scen     = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    port_fifo dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .port_en(port_en), .port_phase(port_phase), .port_din(port_din),
        .port_dout(port_dout), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wide(mem_wide), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .full(full), .empty(empty),
        .overflow(overflow), .underflow(underflow)
    );

    // ---------------- reference model ----------------
    logic [31:0]  q[$];
    int           m_dir, m_mode, m_phase, m_idx;
    logic [95:0]  m_unit;
    bit           m_ovf, m_unf, m_ack;
    logic [PIN_W-1:0] m_dout;
    logic [127:0] m_rdata;

    function automatic int f_w(int m);   return (m == 0) ? 8 : (m == 1) ? 16 : (m == 2) ? 12 : 24; endfunction
    function automatic int f_n(int m);   return (m == 0) ? 4 : (m == 1) ? 2 : (m == 2) ? 8 : 4; endfunction
    function automatic int f_uw(int m);  return (m >= 2) ? 3 : 1; endfunction
    function automatic int f_cap(int m); return (m >= 2) ? 15 : 16; endfunction
    function automatic logic [PIN_W-1:0] f_chunk(logic [95:0] u, int i, int m);
        logic [95:0] s;
        s = u >> (i * f_w(m));
        return s[PIN_W-1:0] & PIN_W'((1 << f_w(m)) - 1);
    endfunction

    task automatic model_clear();
        q.delete();
        m_unit = '0; m_idx = 0; m_ovf = 0; m_unf = 0;
        m_dout = '0; m_ack = 0; m_rdata = '0;
    endtask

    always @(posedge clk) begin
        int  s0, k, w, n, uw, cap;
        bit  tick;
        if (!rst_n) begin
            m_dir = 0; m_mode = 0; m_phase = 0;
            model_clear();
        end else if (cfg_we) begin
            m_dir = cfg_wdata[0]; m_mode = cfg_wdata[2:1]; m_phase = cfg_wdata[5:3];
            model_clear();
        end else begin
            s0 = q.size(); w = f_w(m_mode); n = f_n(m_mode);
            uw = f_uw(m_mode); cap = f_cap(m_mode);
            tick = port_en && (int'(port_phase) == m_phase);
            m_ack = 0;
            k = mem_wide ? 4 : 1;
            if (m_dir == 0) begin
                if (mem_rd && s0 >= k) begin
                    m_rdata = '0;
                    for (int i = 0; i < k; i++) m_rdata[i*32 +: 32] = q.pop_front();
                    m_ack = 1;
                end
                if (tick) begin
                    m_unit = m_unit | (96'(port_din & PIN_W'((1 << w) - 1)) << (m_idx * w));
                    if (m_idx == n - 1) begin
                        if (cap - s0 >= uw) begin
                            for (int i = 0; i < uw; i++) q.push_back(m_unit[i*32 +: 32]);
                        end else m_ovf = 1;
                        m_unit = '0; m_idx = 0;
                    end else m_idx++;
                end
            end else begin
                if (mem_wr && cap - s0 >= k) begin
                    for (int i = 0; i < k; i++) q.push_back(mem_wdata[i*32 +: 32]);
                    m_ack = 1;
                end
                if (tick) begin
                    if (m_idx == 0) begin
                        if (s0 >= uw) begin
                            m_unit = '0;
                            for (int i = 0; i < uw; i++) m_unit[i*32 +: 32] = q.pop_front();
                            m_dout = f_chunk(m_unit, 0, m_mode);
                            m_idx = 1;
                        end else m_unf = 1;
                    end else begin
                        m_dout = f_chunk(m_unit, m_idx, m_mode);
                        m_idx = (m_idx + 1) % n;
                    end
                end
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s actual=%h expected=%h at %0t", req, scen, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            chk("R6", "empty", 128'(empty), 128'(q.size() == 0));
            chk("R6", "full", 128'(full), 128'(f_cap(m_mode) - q.size() < f_uw(m_mode)));
            chk("R7", "overflow", 128'(overflow), 128'(m_ovf));
            chk("R8", "underflow", 128'(underflow), 128'(m_unf));
            chk("R10", "port_dout", 128'(port_dout), 128'(m_dout));
            chk("R9", "mem_ack", 128'(mem_ack), 128'(m_ack));
            if (mem_ack && m_ack) chk("R5", "mem_rdata", mem_rdata, m_rdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cfg(int dir, int mode, int ph);
        cfg_wdata = {26'h2AAAAAA, 3'(ph), 2'(mode), 1'(dir)};  // R2: junk in upper bits
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pev(logic [PIN_W-1:0] d, int ph, bit en = 1'b1);
        port_en = en; port_phase = 3'(ph); port_din = d;
        @(negedge clk);
        port_en = 1'b0;
    endtask

    task automatic mrd(bit wide);
        mem_rd = 1'b1; mem_wide = wide;
        @(negedge clk);
        mem_rd = 1'b0;
    endtask

    task automatic mwr(bit wide, logic [127:0] d);
        mem_wr = 1'b1; mem_wide = wide; mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic idle(int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < MAX_CYC) begin
            @(posedge clk);
            cyc++;
        end
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "empty", 128'(empty), 128'(1));
        chk("R1", "full", 128'(full), 128'(0));
        chk("R1", "flags", 128'({overflow, underflow, mem_ack}), 128'(0));
        chk("R1", "port_dout", 128'(port_dout), 128'(0));
        running = 1'b1;

        // R4: 8-bit packing at default phase 0, upper din bits ignored
        scen = "R4";
        pev(24'hFFFF11, 0); pev(24'hAB0022, 0); pev(24'h000033, 0); pev(24'h123444, 0);
        mrd(0);
        chk("R4", "packed word", mem_rdata, 128'h44332211);

        // R3: wrong phase or no enable ignored
        scen = "R3";
        cfg(0, 0, 2);
        pev(24'h55, 1); pev(24'h66, 3); pev(24'h77, 2, 1'b0);
        pev(24'h01, 2); pev(24'h02, 2); pev(24'h03, 2);
        chk("R3", "still empty", 128'(empty), 128'(1));
        pev(24'h04, 2);
        chk("R3", "one word", 128'(empty), 128'(0));

        // R9: wide read refused with few words, then accepted (R5)
        scen = "R9";
        cfg(0, 1, 5);
        for (int i = 0; i < 6; i++) pev(24'(16'h1000 + i), 5);
        mrd(1);
        chk("R9", "wide refused", 128'(mem_ack), 128'(0));
        pev(24'h2000, 5); pev(24'h2001, 5);
        mrd(1);
        chk("R5", "wide accepted", 128'(mem_ack), 128'(1));
        scen = "R5";
        mrd(0); mrd(0);

        // R4 96-bit: 12-bit and 24-bit units
        scen = "R4-12";
        cfg(0, 2, 1);
        for (int i = 0; i < 8; i++) pev(24'(12'h100 + i), 1);
        mrd(1); mrd(0); mrd(0); mrd(0);
        scen = "R4-24";
        cfg(0, 3, 4);
        for (int i = 0; i < 8; i++) pev(24'hA00000 + 24'(i), 4);
        mrd(1); mrd(0); mrd(0);

        // R7: overflow in 8-bit and 12-bit modes
        scen = "R7";
        cfg(0, 0, 0);
        for (int i = 0; i < 17 * 4; i++) pev(24'(i), 0);
        chk("R7", "overflow set", 128'(overflow), 128'(1));
        mrd(1); mrd(1); mrd(1); mrd(1); mrd(0);
        cfg(0, 2, 0);
        for (int i = 0; i < 6 * 8; i++) pev(24'(i * 3), 0);
        chk("R6", "full at 15 words", 128'(full), 128'(1));

        // R11: control write clears, wins over a same-cycle request
        scen = "R11";
        mem_rd = 1'b1; mem_wide = 1'b0;
        cfg(0, 0, 0);
        mem_rd = 1'b0;
        chk("R11", "cleared", 128'({overflow, empty}), 128'(2'b01));

        // R10 / R8: output 8-bit, underflow and retry
        scen = "R10";
        cfg(1, 0, 3);
        mwr(0, 128'hA1B2C3D4);
        for (int i = 0; i < 4; i++) pev(24'h0, 3);
        chk("R10", "last byte", 128'(port_dout), 128'hA1);
        scen = "R8";
        pev(24'h0, 3);
        chk("R8", "underflow", 128'(underflow), 128'(1));
        chk("R8", "held", 128'(port_dout), 128'hA1);
        mwr(0, 128'h0F0E0D0C);
        pev(24'h0, 3);
        chk("R8", "retry chunk0", 128'(port_dout), 128'h0C);

        // R10 24-bit output from wide writes
        scen = "R10-24";
        cfg(1, 3, 0);
        mwr(1, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111});
        mwr(1, {32'h88888888, 32'h77777777, 32'h66666666, 32'h55555555});
        for (int i = 0; i < 9; i++) pev(24'h0, 0);

        // R12: opposite-direction requests ignored
        scen = "R12";
        mrd(0);
        chk("R12", "read in output mode", 128'(mem_ack), 128'(0));
        cfg(0, 0, 0);
        mwr(0, 128'h1234);
        chk("R12", "write in input mode", 128'(mem_ack), 128'(0));
        chk("R12", "store untouched", 128'(empty), 128'(1));

        // R6 / R9: capacity in 96-bit output mode
        scen = "R6";
        cfg(1, 2, 0);
        for (int i = 0; i < 16; i++) mwr(0, 128'(i));
        chk("R6", "16th narrow refused", 128'(mem_ack), 128'(0));
        mwr(1, '1);

        // Mixed traffic across all modes and directions
        scen = "mix";
        for (int c = 0; c < 6000; c++) begin
            if ((c % 400) == 0) begin
                cfg_wdata = $urandom;
                cfg_wdata[5:3] = 3'($urandom_range(0, 5));
                cfg_we = 1'b1;
            end else cfg_we = 1'b0;
            port_en    = ($urandom_range(0, 1) == 1);
            port_phase = 3'($urandom_range(0, 5));
            port_din   = 24'($urandom);
            mem_rd     = ($urandom_range(0, 3) == 0);
            mem_wr     = ($urandom_range(0, 3) == 0);
            mem_wide   = ($urandom_range(0, 1) == 1);
            mem_wdata  = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
        end
        cfg_we = 1'b0; port_en = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0;
        idle(2);
        running = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule